// File: doc/BRIEF.md
# Associative Overflow Stash

This block is a small, fully associative store of orders that the main hash table could not take. It is used only when both candidate hash slots of an order are already occupied. The parent pipeline inserts an order's reference and payload here. Later it searches the stash by reference to find that order again. A search may also remove the entry it finds, which is how an order is cancelled or executed.

All storage is in flip-flops, one valid bit per entry, so every entry can be compared against the search key in the same cycle. A new order goes into the lowest free entry, which a priority encoder picks. A search returns the matching entry with the lowest index. An occupancy counter and a full flag show how much room is left. An insert that arrives while the stash is full is not stored, and the block reports it as a dropped order.

The nominal build has 1024 entries of 128 bits each (a 64-bit reference and a 64-bit payload). The default parameters are smaller so that simulation stays fast.

Top module: `ovf_stash`

## Requirements
- R1: After reset, `occupancy` is 0, `full` is 0, `ins_drop` is 0 and `res_valid` is 0. Every entry is empty, so any search misses.
- R2: An accepted insert writes into the free entry with the lowest index. An entry freed by a delete is reused before any free entry with a higher index.
- R3: A search presented in cycle N gives `res_valid`=1 in cycle N+1. The result reflects the contents as they stood before the clock edge that ends cycle N, so an insert in cycle N is not visible to that search.
- R4: When several valid entries hold the searched reference, the search returns the one with the lowest index.
- R5: A search with `srch_del`=1 that hits clears the valid bit of the returned entry. A later search for that reference misses, unless another copy exists. A delete request that misses changes no entry and no count.
- R6: `occupancy` rises by one on an accepted insert and falls by one on a delete that hits. It stays unchanged when both happen in the same cycle. It always equals the number of valid entries.
- R7: `full` is 1 exactly when `occupancy` equals DEPTH. An insert while `full` is 1 stores nothing, leaves `occupancy` unchanged and raises `ins_drop` for one cycle in the next cycle. `full` is judged on the state at the start of the cycle, even if a delete happens in that same cycle.
- R8: On a hit, `res_pay` equals the payload stored with the returned entry. On a miss it is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_ref | input | REF_W | Reference of the order to insert |
| ins_pay | input | PAY_W | Payload of the order to insert |
| ins_drop | output | 1 | Insert in the previous cycle was dropped because the stash was full |
| srch_valid | input | 1 | Search request |
| srch_ref | input | REF_W | Reference to search for |
| srch_del | input | 1 | Remove the entry that the search hits |
| res_valid | output | 1 | Search result valid (one cycle after request) |
| res_hit | output | 1 | Search found a valid entry |
| res_pay | output | PAY_W | Payload of the entry found |
| full | output | 1 | Every entry is valid |
| occupancy | output | $clog2(DEPTH+1) | Number of valid entries |

## Verification
The assertions assume that `srch_del` is only meaningful together with `srch_valid`. They also assume that inputs hold defined values from the first clock edge after reset. The bench drives every input to zero during reset and whenever it is idle, so both assumptions hold. Duplicate references are legal at the ports, and the bench inserts them on purpose to exercise lowest-index selection. The count checks do not depend on references being unique. The bench keeps DEPTH small, so it can reach the full state and the full-with-delete case within a few cycles.

// File: rtl/ovf_stash_pkg.sv
package ovf_stash_pkg;

   // bits needed to hold a count from 0 to n
   function automatic int count_bits(input int n);
      return $clog2(n + 1);
   endfunction

   // bits needed to address n entries
   function automatic int index_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/stash_lowest.sv
// Lowest-index selector: one-hot grant, index and any flag.
module stash_lowest #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      grant = req & (~req + N'(1));
      any   = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/stash_match.sv
// Parallel compare of a key against every valid entry.
module stash_match #(
   parameter int DEPTH = 16,
   parameter int REF_W = 64
) (
   input  logic [DEPTH-1:0] vld,
   input  logic [REF_W-1:0] refs [DEPTH],
   input  logic [REF_W-1:0] key,
   output logic [DEPTH-1:0] hit
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = vld[g] && (refs[g] == key);
   end
endmodule

// File: rtl/stash_occ.sv
// Occupancy counter with independent increment and decrement.
module stash_occ #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/ovf_stash.sv
module ovf_stash
   import ovf_stash_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int REF_W      = 64,
   parameter int PAY_W      = 64,
   parameter bit ONEHOT_MUX = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ins_valid,
   input  logic [REF_W-1:0]           ins_ref,
   input  logic [PAY_W-1:0]           ins_pay,
   output logic                       ins_drop,
   input  logic                       srch_valid,
   input  logic [REF_W-1:0]           srch_ref,
   input  logic                       srch_del,
   output logic                       res_valid,
   output logic                       res_hit,
   output logic [PAY_W-1:0]           res_pay,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] occupancy
);
   localparam int CNT_W = count_bits(DEPTH);
   localparam int IDX_W = index_bits(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ovf_stash: DEPTH must be at least 2");
   end
   if (REF_W < 1 || PAY_W < 1) begin : g_bad_width
      $error("ovf_stash: REF_W and PAY_W must be positive");
   end

   logic [DEPTH-1:0] vld_q;
   logic [REF_W-1:0] ref_q [DEPTH];
   logic [PAY_W-1:0] pay_q [DEPTH];

   logic             ins_acc;
   logic [DEPTH-1:0] free_oh;
   logic [IDX_W-1:0] free_idx;
   logic             free_any;
   logic [DEPTH-1:0] hit_vec;
   logic [DEPTH-1:0] hit_oh;
   logic [IDX_W-1:0] hit_idx;
   logic             hit_any;
   logic [DEPTH-1:0] del_oh;
   logic [PAY_W-1:0] rd_pay;

   assign full    = (occupancy == CNT_W'(DEPTH));
   assign ins_acc = ins_valid && !full;

   stash_lowest #(.N(DEPTH), .IDX_W(IDX_W)) u_free (
      .req   (~vld_q),
      .grant (free_oh),
      .idx   (free_idx),
      .any   (free_any)
   );

   stash_match #(.DEPTH(DEPTH), .REF_W(REF_W)) u_match (
      .vld  (vld_q),
      .refs (ref_q),
      .key  (srch_ref),
      .hit  (hit_vec)
   );

   stash_lowest #(.N(DEPTH), .IDX_W(IDX_W)) u_hit (
      .req   (hit_vec),
      .grant (hit_oh),
      .idx   (hit_idx),
      .any   (hit_any)
   );

   assign del_oh = (srch_valid && srch_del) ? hit_oh : '0;

   // payload read: AND-OR over the one-hot grant, or indexed mux
   if (ONEHOT_MUX) begin : g_mux_onehot
      always_comb begin
         rd_pay = '0;
         for (int i = 0; i < DEPTH; i++) begin
            rd_pay = rd_pay | (pay_q[i] & {PAY_W{hit_oh[i]}});
         end
      end
   end else begin : g_mux_index
      assign rd_pay = hit_any ? pay_q[hit_idx] : '0;
   end

   // valid bits: a freed slot and a newly filled slot never coincide
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         vld_q <= (vld_q & ~del_oh) | (ins_acc ? free_oh : '0);
      end
   end

   // entry contents carry no reset; validity is held in vld_q
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (ins_acc && free_oh[i]) begin
            ref_q[i] <= ins_ref;
            pay_q[i] <= ins_pay;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_pay   <= '0;
         ins_drop  <= 1'b0;
      end else begin
         res_valid <= srch_valid;
         res_hit   <= srch_valid && hit_any;
         res_pay   <= srch_valid ? rd_pay : '0;
         ins_drop  <= ins_valid && full;
      end
   end

   stash_occ #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ins_acc),
      .dec   (|del_oh),
      .cnt   (occupancy)
   );

   logic unused_ok;
   assign unused_ok = &{1'b0, free_idx, free_any};
endmodule

// File: rtl/ovf_stash_chk.sv
module ovf_stash_chk #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_valid,
   input logic             srch_del,
   input logic             ins_drop,
   input logic             res_valid,
   input logic             res_hit,
   input logic             full,
   input logic [CNT_W-1:0] occupancy,
   input logic [DEPTH-1:0] vld
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R1: empty on the first edge after reset release
   a_r1_reset_empty: assert property (@(posedge clk)
      $rose(rst_n) |-> (occupancy == '0 && vld == '0));

   // R6: counter agrees with the valid bits of the array
   a_r6_occ_matches_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld) == int'(occupancy));

   // R6: step follows accepted inserts and deletes that hit
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (int'(occupancy) == int'($past(occupancy))
                + int'($past(ins_valid && !full))
                - int'(res_valid && res_hit && $past(srch_del))));

   // R7: count never exceeds capacity
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occupancy) <= DEPTH);

   // R7: a drop only follows a cycle in which the stash was full
   a_r7_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && ins_drop) |-> int'($past(occupancy)) == DEPTH);

   // R3: a hit implies something was stored before the search
   a_r3_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && res_valid && res_hit) |-> $past(occupancy) != '0);
endmodule

bind ovf_stash ovf_stash_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ins_valid (ins_valid),
   .srch_del  (srch_del),
   .ins_drop  (ins_drop),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .full      (full),
   .occupancy (occupancy),
   .vld       (vld_q)
);

// File: tb/sim_ovf_stash.sv
module sim_ovf_stash;
   localparam int DEPTH = 4;
   localparam int REF_W = 64;
   localparam int PAY_W = 64;
   localparam int CW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ins_valid = 1'b0, srch_valid = 1'b0, srch_del = 1'b0;
   logic [REF_W-1:0] ins_ref = '0, srch_ref = '0;
   logic [PAY_W-1:0] ins_pay = '0;
   logic ins_drop, res_valid, res_hit, full;
   logic [PAY_W-1:0] res_pay;
   logic [CW-1:0] occupancy;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ovf_stash #(.DEPTH(DEPTH), .REF_W(REF_W), .PAY_W(PAY_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_ref(ins_ref), .ins_pay(ins_pay), .ins_drop(ins_drop),
      .srch_valid(srch_valid), .srch_ref(srch_ref), .srch_del(srch_del),
      .res_valid(res_valid), .res_hit(res_hit), .res_pay(res_pay),
      .full(full), .occupancy(occupancy)
   );

   typedef struct packed {
      logic        ins;
      logic [63:0] iref;
      logic [63:0] ipay;
      logic        srch;
      logic        del;
      logic [63:0] sref;
      logic        ehit;
      logic [63:0] epay;
      logic [7:0]  eocc;
      logic        edrop;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 64'h11, 64'hA1, 1'b0, 1'b0, 64'h0,  1'b0, 64'h0,  8'd1, 1'b0},
      '{1'b1, 64'h22, 64'hB2, 1'b1, 1'b0, 64'h11, 1'b1, 64'hA1, 8'd2, 1'b0},
      '{1'b1, 64'h33, 64'hC3, 1'b1, 1'b0, 64'h33, 1'b0, 64'h0,  8'd3, 1'b0},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b0, 64'h33, 1'b1, 64'hC3, 8'd3, 1'b0},
      '{1'b1, 64'h11, 64'hD4, 1'b0, 1'b0, 64'h0,  1'b0, 64'h0,  8'd4, 1'b0},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b0, 64'h11, 1'b1, 64'hA1, 8'd4, 1'b0},
      '{1'b1, 64'h44, 64'hE5, 1'b0, 1'b0, 64'h0,  1'b0, 64'h0,  8'd4, 1'b1},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b0, 64'h44, 1'b0, 64'h0,  8'd4, 1'b0},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b1, 64'h11, 1'b1, 64'hA1, 8'd3, 1'b0},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b0, 64'h11, 1'b1, 64'hD4, 8'd3, 1'b0},
      '{1'b1, 64'h55, 64'hF6, 1'b1, 1'b1, 64'h22, 1'b1, 64'hB2, 8'd3, 1'b0},
      '{1'b1, 64'h66, 64'h07, 1'b0, 1'b0, 64'h0,  1'b0, 64'h0,  8'd4, 1'b0},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b1, 64'h99, 1'b0, 64'h0,  8'd4, 1'b0},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b1, 64'h55, 1'b1, 64'hF6, 8'd3, 1'b0},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b0, 64'h66, 1'b1, 64'h07, 8'd3, 1'b0},
      '{1'b1, 64'h33, 64'h88, 1'b0, 1'b0, 64'h0,  1'b0, 64'h0,  8'd4, 1'b0},
      '{1'b0, 64'h0,  64'h0,  1'b1, 1'b0, 64'h33, 1'b1, 64'h88, 8'd4, 1'b0}
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic i, input logic [63:0] ir, input logic [63:0] ip,
                        input logic s, input logic d, input logic [63:0] sr);
      ins_valid = i; ins_ref = ir; ins_pay = ip;
      srch_valid = s; srch_del = d; srch_ref = sr;
   endtask

   task automatic idle();
      drive(1'b0, '0, '0, 1'b0, 1'b0, '0);
   endtask

   // one operation, sampled at the next falling edge
   task automatic step(input vec_t v, input string tag);
      drive(v.ins, v.iref, v.ipay, v.srch, v.del, v.sref);
      @(negedge clk);
      idle();
      if (v.srch) begin
         check(res_valid == 1'b1, {tag, " R3 res_valid"}, 64'(res_valid), 64'd1);
         check(res_hit == v.ehit, {tag, " R4 R5 hit"}, 64'(res_hit), 64'(v.ehit));
         check(res_pay == v.epay, {tag, " R8 payload"}, res_pay, v.epay);
      end
      check(int'(occupancy) == int'(v.eocc), {tag, " R6 occupancy"},
            64'(occupancy), 64'(v.eocc));
      check(full == (v.eocc == 8'(DEPTH)), {tag, " R7 full"}, 64'(full),
            64'(v.eocc == 8'(DEPTH)));
      check(ins_drop == v.edrop, {tag, " R7 drop"}, 64'(ins_drop), 64'(v.edrop));
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(occupancy == '0 && !full && !ins_drop && !res_valid, "R1 reset outputs",
            64'(occupancy), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R2 R3 R4 R5 R6 R7 R8 (entries 2, 10 and 15 cover R3 and R2)
      for (int k = 0; k < NV; k++) begin
         step(VEC[k], $sformatf("vec%0d", k));
      end

      // R1: reset in the middle of a run empties the stash
      rst_n = 1'b0;
      @(negedge clk);
      check(occupancy == '0 && !full, "R1 mid-run reset", 64'(occupancy), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      v = '{1'b0, 64'h0, 64'h0, 1'b1, 1'b0, 64'h66, 1'b0, 64'h0, 8'd0, 1'b0};
      step(v, "R1 search after reset");

      // fill, then insert and delete together while full: R7 insert dropped
      for (int k = 0; k < DEPTH; k++) begin
         v = '{1'b1, 64'(32'h70 + k), 64'(32'h900 + k), 1'b0, 1'b0, 64'h0, 1'b0, 64'h0,
               8'(k + 1), 1'b0};
         step(v, "fill");
      end
      v = '{1'b1, 64'h7F, 64'hEE, 1'b1, 1'b1, 64'h71, 1'b1, 64'h901, 8'd3, 1'b1};
      step(v, "R7 full with delete");
      v = '{1'b0, 64'h0, 64'h0, 1'b1, 1'b0, 64'h7F, 1'b0, 64'h0, 8'd3, 1'b0};
      step(v, "R7 dropped not stored");
      // R2: the freed slot 1 is reused, then search finds other entries intact
      v = '{1'b1, 64'h72, 64'hAB, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 8'd4, 1'b0};
      step(v, "R2 refill");
      v = '{1'b0, 64'h0, 64'h0, 1'b1, 1'b0, 64'h72, 1'b1, 64'hAB, 8'd4, 1'b0};
      step(v, "R2 R4 reuse lower slot");

      summary();
   end
endmodule